// File: doc/BRIEF.md
# Video Link Framer with Retrace Side-Channel

This block sits between a parallel video source and a serial line driver. On every pixel clock it takes a 16-bit pixel, the horizontal and vertical sync lines and a data-enable flag. It returns a 20-bit word that holds two DC-balanced 8b/10b symbols. During active video the two symbols carry the pixel. During blanking they carry control characters. Outside active video the block sends a marker at the leading edge of each horizontal sync, so a receiver that has just been plugged in can find symbol alignment again. It sends a second marker at the leading edge of each vertical sync.

While vertical sync is asserted, each pixel slot that is otherwise idle can carry one auxiliary byte. The byte is taken from a show-ahead byte FIFO: `aux_avail` means the head entry `aux_data` is valid, and `aux_pop` removes that entry in the same cycle. Each auxiliary byte follows its own start character. The side-channel therefore uses no bandwidth beyond the slots that blanking already provides.

A polarity input makes the block accept either active-high or active-low syncs. The running disparity is carried from one symbol to the next, across both slots and across pixel clocks.

Top module: `vlink_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output becomes 20'h3EB05 and the running disparity becomes negative. 20'h3EB05 is an idle comma in its negative-disparity form, followed by an idle comma in its positive-disparity form.
- R2: When `de` is high, the output one clock later carries `pix_data[15:8]` in the first slot (bits 19:10) and `pix_data[7:0]` in the second slot (bits 9:0), both as data characters.
- R3: With `sync_pol`=0 the syncs are active high. With `sync_pol`=1 they are active low. The rest of the behaviour does not depend on the polarity.
- R4: A leading edge of the normalised horizontal sync with `de` low produces {line marker K28.0, idle K28.5}. The marker appears once per edge and is not repeated while the sync stays asserted.
- R5: A leading edge of the normalised vertical sync, with `de` low and no horizontal edge in the same cycle, produces {frame marker K28.4, idle K28.5}.
- R6: While the normalised vertical sync is asserted, with no marker due and `de` low, `aux_avail` high makes `aux_pop` high in the same cycle. The output one clock later is {aux start K28.2, `aux_data` as a data character}.
- R7: `aux_pop` stays low outside vertical sync, while `de` is high, on a marker cycle, or when `aux_avail` is low. A slot with nothing to send carries idle K28.5 in both halves.
- R8: Every symbol has 4, 5 or 6 ones. A 6-ones symbol occurs only at negative running disparity and a 4-ones symbol only at positive running disparity. Each symbol uses the standard 8b/10b form for the current disparity, including the alternate x.7 form.
- R9: Within a symbol, bit 9 is the first bit on the line ('a'). The 6-bit sub-block occupies bits 9:4 and the 4-bit sub-block occupies bits 3:0.
- R10: The priority is: active data, then line marker, then frame marker, then auxiliary byte, then idle. A sync edge that coincides with `de` is consumed and produces no marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pol | input | 1 | 1: syncs active low, 0: active high |
| pix_data | input | 16 | Pixel word |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| aux_data | input | 8 | Head byte of the auxiliary FIFO |
| aux_avail | input | 1 | Auxiliary FIFO not empty |
| aux_pop | output | 1 | Pops the auxiliary FIFO this cycle |
| sym_out | output | 20 | Two symbols, first slot in bits 19:10 |

## Verification
The bench drives sync edges that coincide with data-enable and with each other. A design that applies the priority wrongly would emit a marker in place of pixel data, or would pop an auxiliary byte that is then lost. It checks that a held sync produces only one marker and that an active-low sync is recognised on its falling edge. A level-triggered or polarity-blind design would send repeated or misplaced markers. Every symbol is checked against the disparity the bench tracks from the ones counts it observes, and the pixel codes are chosen to reach the alternate x.7 form and both disparity forms. A design that forgot the alternate code, or carried the disparity wrongly between the two slots, would produce an illegal or unbalanced symbol.

// File: rtl/vlink_framer.sv
module vlink_framer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_pol,
  input  logic [15:0] pix_data,
  input  logic        hsync,
  input  logic        vsync,
  input  logic        de,
  input  logic [7:0]  aux_data,
  input  logic        aux_avail,
  output logic        aux_pop,
  output logic [19:0] sym_out
);
  localparam logic [9:0] K_LINE  = 10'b0011110100;
  localparam logic [9:0] K_FRAME = 10'b0011110010;
  localparam logic [9:0] K_AUX   = 10'b0011110101;
  localparam logic [9:0] K_IDLE  = 10'b0011111010;
  localparam logic [19:0] RST_WORD = {K_IDLE, ~K_IDLE};

  logic rd, hs_q, vs_q;
  logic hs_n, vs_n, hs_edge, vs_edge;
  logic [10:0] r0, r1;

  assign hs_n    = hsync ^ sync_pol;
  assign vs_n    = vsync ^ sync_pol;
  assign hs_edge = hs_n & ~hs_q;
  assign vs_edge = vs_n & ~vs_q;
  assign aux_pop = ~de & ~hs_edge & ~vs_edge & vs_n & aux_avail;

  function automatic logic [10:0] enc_k(input logic [9:0] kneg, input logic rdi);
    logic [9:0] c;
    c = rdi ? ~kneg : kneg;
    return {($countones(c) == 5) ? rdi : ~rdi, c};
  endfunction

  function automatic logic [10:0] enc_d(input logic [7:0] b, input logic rdi);
    logic [5:0] s;
    logic [3:0] f;
    logic       mid, u6, u4, alt;
    logic [4:0] x;
    x = b[4:0];
    case (x)
      5'd0:  s = 6'b100111; 5'd1:  s = 6'b011101; 5'd2:  s = 6'b101101; 5'd3:  s = 6'b110001;
      5'd4:  s = 6'b110101; 5'd5:  s = 6'b101001; 5'd6:  s = 6'b011001; 5'd7:  s = 6'b111000;
      5'd8:  s = 6'b111001; 5'd9:  s = 6'b100101; 5'd10: s = 6'b010101; 5'd11: s = 6'b110100;
      5'd12: s = 6'b001101; 5'd13: s = 6'b101100; 5'd14: s = 6'b011100; 5'd15: s = 6'b010111;
      5'd16: s = 6'b011011; 5'd17: s = 6'b100011; 5'd18: s = 6'b010011; 5'd19: s = 6'b110010;
      5'd20: s = 6'b001011; 5'd21: s = 6'b101010; 5'd22: s = 6'b011010; 5'd23: s = 6'b111010;
      5'd24: s = 6'b110011; 5'd25: s = 6'b100110; 5'd26: s = 6'b010110; 5'd27: s = 6'b110110;
      5'd28: s = 6'b001110; 5'd29: s = 6'b101110; 5'd30: s = 6'b011110; default: s = 6'b101011;
    endcase
    u6  = ($countones(s) != 3);
    if (rdi && (u6 || s == 6'b111000)) s = ~s;
    mid = u6 ? ~rdi : rdi;
    alt = (b[7:5] == 3'd7) &&
          ((!mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           ( mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    case (b[7:5])
      3'd0: f = 4'b1011; 3'd1: f = 4'b1001; 3'd2: f = 4'b0101; 3'd3: f = 4'b1100;
      3'd4: f = 4'b1101; 3'd5: f = 4'b1010; 3'd6: f = 4'b0110;
      default: f = alt ? 4'b0111 : 4'b1110;
    endcase
    u4 = ($countones(f) != 2);
    if (mid && (u4 || f == 4'b1100)) f = ~f;
    return {u4 ? ~mid : mid, s, f};
  endfunction

  always_comb begin
    if (de) begin
      r0 = enc_d(pix_data[15:8], rd);
      r1 = enc_d(pix_data[7:0], r0[10]);
    end else if (hs_edge) begin
      r0 = enc_k(K_LINE, rd);
      r1 = enc_k(K_IDLE, r0[10]);
    end else if (vs_edge) begin
      r0 = enc_k(K_FRAME, rd);
      r1 = enc_k(K_IDLE, r0[10]);
    end else if (aux_pop) begin
      r0 = enc_k(K_AUX, rd);
      r1 = enc_d(aux_data, r0[10]);
    end else begin
      r0 = enc_k(K_IDLE, rd);
      r1 = enc_k(K_IDLE, r0[10]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd      <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      sym_out <= RST_WORD;
    end else begin
      rd      <= r1[10];
      hs_q    <= hs_n;
      vs_q    <= vs_n;
      sym_out <= {r0[9:0], r1[9:0]};
    end
  end

  // R8
  sym_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sym_out[19:10]) >= 4 && $countones(sym_out[19:10]) <= 6 &&
    $countones(sym_out[9:0]) >= 4 && $countones(sym_out[9:0]) <= 6);
  // R8
  neg_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $countones(sym_out[19:10]) >= 5);
  // R2
  data_no_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |=> (sym_out[19:14] != 6'b001111 && sym_out[19:14] != 6'b110000));
  // R4
  line_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge && !de) |=> (sym_out[19:10] == K_LINE || sym_out[19:10] == ~K_LINE));
  // R6
  aux_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_pop |=> (sym_out[19:10] == K_AUX || sym_out[19:10] == ~K_AUX));
endmodule

// File: tb/tb_vlink_framer.sv
`timescale 1ns/1ps
module tb_vlink_framer;
  logic clk = 0, rst_n = 0, sync_pol = 0, hsync = 0, vsync = 0, de = 0, aux_avail = 0;
  logic [15:0] pix_data = 0;
  logic [7:0]  aux_data = 0;
  logic        aux_pop;
  logic [19:0] sym_out;
  int checks = 0, errors = 0;
  logic brd = 0, rd0, rd1, last_pop;
  logic [9:0] s0, s1;

  localparam logic [8:0] KL = {1'b1, 8'h1C}, KF = {1'b1, 8'h9C},
                         KA = {1'b1, 8'h5C}, KI = {1'b1, 8'hBC};

  vlink_framer dut (.*);

  always #2 clk = ~clk;

  function automatic logic [9:0] exp_sym(input logic [8:0] ch, input logic rd);
    logic [9:0] n;
    case (ch)
      KL: n = 10'b0011110100;
      KF: n = 10'b0011110010;
      KA: n = 10'b0011110101;
      KI: n = 10'b0011111010;
      default: n = 10'b0;
    endcase
    if (ch[8]) return rd ? ~n : n;
    case (ch[7:0])
      8'h00: return rd ? 10'b0110001011 : 10'b1001110100;
      8'hF1: return rd ? 10'b1000110001 : 10'b1000110111;
      8'hFF: return rd ? 10'b0101001110 : 10'b1010110001;
      8'hB5: return 10'b1010101010;
      default: return 10'b0;
    endcase
  endfunction

  task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic track(input logic [9:0] s);
    int n;
    n = $countones(s);
    checks++;
    if (n == 5) begin
    end else if (n == 6 && !brd) brd = 1;
    else if (n == 4 && brd) brd = 0;
    else begin
      errors++;
      $display("FAIL R8 actual=%b ones=%0d expected=legal weight at rd=%0d", s, n, brd);
    end
  endtask

  task automatic cyc(input logic d, input logic h, input logic v, input logic [15:0] px,
                     input logic av, input logic [7:0] ad);
    de = d; hsync = h; vsync = v; pix_data = px; aux_avail = av; aux_data = ad;
    #1 last_pop = aux_pop;
    @(posedge clk); #1;
    s0 = sym_out[19:10]; s1 = sym_out[9:0];
    rd0 = brd; track(s0);
    rd1 = brd; track(s1);
    @(negedge clk);
  endtask

  task automatic expect_pair(input logic [8:0] c0, input logic [8:0] c1, input string tag);
    chk({s0, s1}, {exp_sym(c0, rd0), exp_sym(c1, rd1)}, tag);
  endtask

  task automatic t_reset;
    chk(sym_out, 20'h3EB05, "R1 reset word");
    brd = 0;
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, 0);
    expect_pair(KI, KI, "R1 idle after reset starts at negative disparity");
  endtask

  task automatic t_active;
    cyc(1, 0, 0, 16'h0000, 0, 0); expect_pair(9'h000, 9'h000, "R2 pixel 0000");
    cyc(1, 0, 0, 16'hF100, 0, 0); expect_pair(9'h0F1, 9'h000, "R2 R8 R9 pixel F100 alternate x.7");
    cyc(1, 0, 0, 16'hFFFF, 0, 0); expect_pair(9'h0FF, 9'h0FF, "R2 R9 pixel FFFF");
    cyc(1, 0, 0, 16'hB5B5, 0, 0); expect_pair(9'h0B5, 9'h0B5, "R2 pixel B5B5");
    cyc(1, 0, 0, 16'h00F1, 0, 0); expect_pair(9'h000, 9'h0F1, "R2 R8 pixel 00F1");
  endtask

  task automatic t_hsync;
    cyc(0, 1, 0, 0, 1, 8'hB5); expect_pair(KL, KI, "R4 line marker");
    chk({19'd0, last_pop}, 20'd0, "R7 no pop outside vsync");
    cyc(0, 1, 0, 0, 0, 0); expect_pair(KI, KI, "R4 held sync gives idle");
    cyc(0, 0, 0, 0, 0, 0); expect_pair(KI, KI, "R7 idle");
  endtask

  task automatic t_pol;
    sync_pol = 1;
    cyc(0, 1, 1, 0, 0, 0); expect_pair(KI, KI, "R3 inactive high syncs");
    cyc(0, 0, 1, 0, 0, 0); expect_pair(KL, KI, "R3 active-low line edge");
    cyc(0, 1, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0); expect_pair(KF, KI, "R3 R5 active-low frame edge");
    cyc(0, 1, 1, 0, 0, 0);
    sync_pol = 0;
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_aux;
    cyc(0, 0, 1, 0, 1, 8'hB5); expect_pair(KF, KI, "R5 frame marker");
    chk({19'd0, last_pop}, 20'd0, "R7 no pop on marker");
    cyc(0, 0, 1, 0, 1, 8'hB5); expect_pair(KA, 9'h0B5, "R6 aux byte B5");
    chk({19'd0, last_pop}, 20'd1, "R6 pop");
    cyc(0, 0, 1, 0, 1, 8'hF1); expect_pair(KA, 9'h0F1, "R6 aux byte F1");
    cyc(0, 0, 1, 0, 0, 8'h00); expect_pair(KI, KI, "R7 empty fifo idle");
    chk({19'd0, last_pop}, 20'd0, "R7 no pop when empty");
    cyc(1, 0, 1, 16'h00FF, 1, 8'hB5); expect_pair(9'h000, 9'h0FF, "R10 data over aux");
    chk({19'd0, last_pop}, 20'd0, "R7 no pop during de");
    cyc(0, 1, 1, 0, 1, 8'hB5); expect_pair(KL, KI, "R10 line marker over aux");
    chk({19'd0, last_pop}, 20'd0, "R7 no pop on line marker");
    cyc(0, 0, 0, 0, 1, 8'hB5); expect_pair(KI, KI, "R7 aux held outside vsync");
    chk({19'd0, last_pop}, 20'd0, "R7 no pop after vsync");
  endtask

  task automatic t_prio;
    cyc(1, 1, 1, 16'hB500, 0, 0); expect_pair(9'h0B5, 9'h000, "R10 data over both edges");
    cyc(0, 1, 1, 0, 0, 0); expect_pair(KI, KI, "R10 edges consumed");
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0); expect_pair(KL, KI, "R10 line marker over frame marker");
    cyc(0, 1, 1, 0, 0, 0); expect_pair(KI, KI, "R10 frame edge consumed");
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_active;
    t_hsync;
    t_pol;
    t_aux;
    t_prio;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule